// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A single-port synchronous memory for use as the data store of a cache that sits behind a processor bus. Address, write data, byte lanes and all cycle controls are captured on the rising clock edge. Burst order and output enable are the only inputs that act without the clock. Two address strobes can start an access. One strobe belongs to the processor and can only start reads. The other belongs to the cache controller and can start a read or a write. After the start, an advance input steps a two-bit burst counter or holds it. The counter steps in linear (wrapping add) or interleaved (XOR) order.

Reads are pipelined. The word addressed on edge n is read from the array into a staging register at that edge, moves to the output register on edge n+1, and is driven while the output enable is low. Writes go into the array on the sampling edge. They can be global (all lanes) or limited to selected byte lanes. A deselect stops the data drive one clock after it is sampled, which is the same depth as the read pipeline.

Top module: `pbsram`

## Requirements
- R1: A start cycle, in which either strobe is effectively low, loads the external address when the chip is selected. Selected means `sel_n`=0, `bank_hi`=1 and `bank_lo_n`=0. A read start returns the word at that address.
- R2: `strobe_cpu_n` low while `sel_n` is high is ignored. With `strobe_ctl_n` high, the cycle acts as a continue or suspend of the current burst, chosen by `burst_adv_n`, and the chip stays selected.
- R3: A start cycle with the chip not selected deselects it. This includes `strobe_ctl_n` low with `sel_n` high, `bank_hi` low, or `bank_lo_n` high. `dq_oe` is 0 after the next clock edge.
- R4: With `burst_xor`=0, each continue cycle (both strobes high, `burst_adv_n`=0) uses low address bits (base + k) mod 4. The upper bits stay fixed, so the burst wraps within a block of four words.
- R5: With `burst_xor`=1, the k-th word of a burst uses low address bits base XOR k.
- R6: A suspend cycle (both strobes high, `burst_adv_n`=1) reuses the current address, for reads and for writes.
- R7: A cycle started by `strobe_cpu_n` on a selected chip is always a read, whatever the write inputs are.
- R8: A write can happen on a start by `strobe_ctl_n`, or on a continue or suspend cycle.
- R9: `wr_all_n`=0 writes all four byte lanes. Otherwise, with `wr_en_n`=0, a lane is written when its `byte_wr_n` bit is 0; bit i controls `dq_in[8i+7:8i]`. With `wr_en_n`=0 and all `byte_wr_n` bits at 1, the cycle is a read.
- R10: The data of a read sampled on edge n is on `dq_out` with `dq_oe`=1 after edge n+1.
- R11: `out_en_n` gates `dq_oe` without the clock. In the clock period after a write is sampled, `dq_oe` is 0 whatever `out_en_n` is.
- R12: While deselected, cycles with both strobes high neither write nor drive. A new start is needed.
- R13: After reset the chip is deselected and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| dq_in | input | DATA_W | Write data |
| strobe_cpu_n | input | 1 | Processor address strobe, active low, read only |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Primary chip select, active low |
| bank_hi | input | 1 | Depth-expansion select, active high |
| bank_lo_n | input | 1 | Depth-expansion select, active low |
| wr_all_n | input | 1 | Global write, active low |
| wr_en_n | input | 1 | Byte-lane write enable, active low |
| byte_wr_n | input | DATA_W/8 | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| burst_xor | input | 1 | Burst order: 0 linear, 1 interleaved |
| dq_out | output | DATA_W | Registered read data |
| dq_oe | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with ADDR_W=6, DATA_W=32 and CNT_W=2. With 64 words the bench can fill every location with known data before any read, so each read and every wrap of a four-word burst is compared against a fully defined reference. The default burst width keeps both orderings short enough to walk from every base offset that is used. The reference model follows the strobe, select and write-enable rules on its own and predicts, for every cycle, both the bus drive and the data two edges later.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_DESEL,
    CYC_BEGIN,
    CYC_CONT,
    CYC_SUSP
  } cyc_e;
endpackage

// File: rtl/pbsram_decode.sv
module pbsram_decode
  import pbsram_pkg::*;
#(
  parameter int BYTES = 4
) (
  input  logic             strobe_cpu_n,
  input  logic             strobe_ctl_n,
  input  logic             adv_n,
  input  logic             sel_n,
  input  logic             bank_hi,
  input  logic             bank_lo_n,
  input  logic             wr_all_n,
  input  logic             wr_en_n,
  input  logic [BYTES-1:0] byte_wr_n,
  input  logic             active,
  output cyc_e             cyc,
  output logic             load,
  output logic             advance,
  output logic             rd,
  output logic [BYTES-1:0] wmask
);
  logic             cpu_start;
  logic             any_start;
  logic             chip_on;
  logic             wr_ok;
  logic [BYTES-1:0] req_mask;

  always_comb begin
    // processor strobe only counts when the primary select is active
    cpu_start = !strobe_cpu_n && !sel_n;
    any_start = cpu_start || !strobe_ctl_n;
    chip_on   = !sel_n && bank_hi && !bank_lo_n;

    if (!wr_all_n)     req_mask = '1;
    else if (!wr_en_n) req_mask = ~byte_wr_n;
    else               req_mask = '0;

    if (any_start)   cyc = chip_on ? CYC_BEGIN : CYC_DESEL;
    else if (active) cyc = adv_n ? CYC_SUSP : CYC_CONT;
    else             cyc = CYC_IDLE;

    load    = (cyc == CYC_BEGIN);
    advance = (cyc == CYC_CONT);
    // processor-started cycles are reads only
    wr_ok   = ((cyc == CYC_BEGIN) && !cpu_start) || (cyc == CYC_CONT) || (cyc == CYC_SUSP);
    wmask   = wr_ok ? req_mask : '0;
    rd      = (cyc inside {CYC_BEGIN, CYC_CONT, CYC_SUSP}) && (wmask == '0);
  end
endmodule

// File: rtl/pbsram_burst.sv
module pbsram_burst #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              burst_xor,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [CNT_W-1:0]  cnt
);
  localparam int HI_W = ADDR_W - CNT_W;

  logic [HI_W-1:0]  hi_q, hi_d;
  logic [CNT_W-1:0] base_q, base_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    hi_d   = hi_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    if (load) begin
      hi_d   = ext_addr[ADDR_W-1:CNT_W];
      base_d = ext_addr[CNT_W-1:0];
      cnt_d  = '0;
    end else if (advance) begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
    // address used on this edge comes from the next-state values
    acc_addr = {hi_d, burst_xor ? (base_d ^ cnt_d) : (base_d + cnt_d)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      hi_q   <= hi_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pbsram_array.sv
module pbsram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W/8-1:0] wmask,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BYTES = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int b = 0; b < BYTES; b++) begin
      if (wmask[b]) mem[addr][b*8 +: 8] <= wdata[b*8 +: 8];
    end
    if (rd_en) rdata <= mem[addr];
  end
endmodule

// File: rtl/pbsram.sv
module pbsram
  import pbsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   dq_in,
  input  logic                strobe_cpu_n,
  input  logic                strobe_ctl_n,
  input  logic                burst_adv_n,
  input  logic                sel_n,
  input  logic                bank_hi,
  input  logic                bank_lo_n,
  input  logic                wr_all_n,
  input  logic                wr_en_n,
  input  logic [DATA_W/8-1:0] byte_wr_n,
  input  logic                out_en_n,
  input  logic                burst_xor,
  output logic [DATA_W-1:0]   dq_out,
  output logic                dq_oe
);
  localparam int BYTES = DATA_W / 8;

  cyc_e              cyc;
  logic              load, advance, rd_now, wr_any;
  logic [BYTES-1:0]  wmask;
  logic [ADDR_W-1:0] acc_addr;
  logic [CNT_W-1:0]  burst_cnt;
  logic              active_q, active_d;
  logic              rdv_q, drv_q, wr_q;
  logic [DATA_W-1:0] arr_q, dq_q;

  pbsram_decode #(.BYTES(BYTES)) dec_i (
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n), .adv_n(burst_adv_n),
    .sel_n(sel_n), .bank_hi(bank_hi), .bank_lo_n(bank_lo_n),
    .wr_all_n(wr_all_n), .wr_en_n(wr_en_n), .byte_wr_n(byte_wr_n),
    .active(active_q), .cyc(cyc), .load(load), .advance(advance),
    .rd(rd_now), .wmask(wmask)
  );

  pbsram_burst #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
    .burst_xor(burst_xor), .ext_addr(addr), .acc_addr(acc_addr), .cnt(burst_cnt)
  );

  pbsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) arr_i (
    .clk(clk), .addr(acc_addr), .wmask(wmask), .wdata(dq_in),
    .rd_en(rd_now), .rdata(arr_q)
  );

  always_comb begin
    wr_any = |wmask;
    case (cyc)
      CYC_DESEL: active_d = 1'b0;
      CYC_BEGIN: active_d = 1'b1;
      default:   active_d = active_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rdv_q    <= 1'b0;
      drv_q    <= 1'b0;
      wr_q     <= 1'b0;
    end else begin
      active_q <= active_d;
      rdv_q    <= rd_now;
      drv_q    <= rdv_q;
      wr_q     <= wr_any;
    end
  end

  // output data register, loaded only when a read leaves the array stage
  always_ff @(posedge clk) begin
    if (rdv_q) dq_q <= arr_q;
  end

  assign dq_out = dq_q;
  assign dq_oe  = drv_q & ~wr_q & ~out_en_n;
endmodule

// File: rtl/pbsram_chk.sv
module pbsram_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             strobe_cpu_n,
  input logic             strobe_ctl_n,
  input logic             burst_adv_n,
  input logic             sel_n,
  input logic             active_q,
  input logic             wr_any,
  input logic             dq_oe,
  input logic [CNT_W-1:0] burst_cnt
);
  assert_cpu_strobe_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu_n && sel_n && strobe_ctl_n) |=> $stable(active_q));

  assert_deselect_quiets_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_ctl_n && sel_n) |-> ##2 !dq_oe);

  assert_advance_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_cpu_n && strobe_ctl_n && !burst_adv_n && active_q)
      |=> (burst_cnt == $past(burst_cnt) + CNT_W'(1)));

  assert_suspend_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((strobe_cpu_n || sel_n) && strobe_ctl_n && burst_adv_n) |=> $stable(burst_cnt));

  assert_cpu_start_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu_n && !sel_n) |-> !wr_any);

  assert_write_quiets_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> !dq_oe);

  assert_idle_no_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && strobe_cpu_n && strobe_ctl_n) |-> !wr_any);
endmodule

bind pbsram pbsram_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
  .burst_adv_n(burst_adv_n), .sel_n(sel_n), .active_q(active_q), .wr_any(wr_any),
  .dq_oe(dq_oe), .burst_cnt(burst_cnt)
);

// File: tb/pbsram_tb_top.sv
module pbsram_tb_top;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int BW = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in;
  logic          cpu_n, ctl_n, adv_n, sel_n, bank_hi, bank_lo_n, all_n, we_n;
  logic [BW-1:0] bwr_n;
  logic          oe_n, xor_ord;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  pbsram #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .dq_in(dq_in),
    .strobe_cpu_n(cpu_n), .strobe_ctl_n(ctl_n), .burst_adv_n(adv_n),
    .sel_n(sel_n), .bank_hi(bank_hi), .bank_lo_n(bank_lo_n),
    .wr_all_n(all_n), .wr_en_n(we_n), .byte_wr_n(bwr_n),
    .out_en_n(oe_n), .burst_xor(xor_ord), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  typedef struct {
    int            due;
    bit            drv;
    logic [DW-1:0] data;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   edges = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   mode_il = 1'b0;

  // reference state
  logic [DW-1:0]   rmem [DEPTH];
  bit              r_act;
  logic [AW-3:0]   r_hi;
  logic [1:0]      r_base, r_cnt;

  always @(posedge clk) edges++;

  function automatic logic [DW-1:0] pat(int a);
    return (32'(a) * 32'h0101_0101) ^ 32'hA5C3_0F00;
  endfunction

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // driver: apply one cycle, update reference, push the expected bus state
  task automatic op(input logic p, input logic c, input logic v,
                    input logic e1, input logic e2, input logic e3,
                    input logic g, input logic w, input logic [BW-1:0] b,
                    input int a, input logic [DW-1:0] d, input string tag);
    bit effp, start, sel, rd, wr;
    logic [BW-1:0] m;
    logic [AW-1:0] ea;
    exp_t it, prev;
    @(negedge clk);
    cpu_n = p; ctl_n = c; adv_n = v; sel_n = e1; bank_hi = e2; bank_lo_n = e3;
    all_n = g; we_n = w; bwr_n = b; addr = AW'(a); dq_in = d; xor_ord = mode_il;
    effp  = !p && !e1;
    start = effp || !c;
    sel   = !e1 && e2 && !e3;
    m     = !g ? '1 : (!w ? ~b : '0);
    rd = 1'b0; wr = 1'b0;
    if (start) begin
      if (sel) begin
        r_act = 1'b1; r_hi = a[AW-1:2]; r_base = a[1:0]; r_cnt = 2'd0;
        wr = (m != '0) && !effp; rd = !wr;
      end else r_act = 1'b0;
    end else if (r_act) begin
      if (!v) r_cnt = r_cnt + 2'd1;
      wr = (m != '0); rd = !wr;
    end
    ea = {r_hi, mode_il ? (r_base ^ r_cnt) : (r_base + r_cnt)};
    if (wr) begin
      for (int i = 0; i < BW; i++) if (m[i]) rmem[ea][i*8 +: 8] = d[i*8 +: 8];
      // R11: a write cycle silences the bus for the previous read's slot
      if (q.size() > 0 && q[q.size()-1].due == edges + 1) begin
        prev = q.pop_back();
        prev.drv = 1'b0;
        q.push_back(prev);
      end
    end
    it.due = edges + 2; it.drv = rd; it.data = rd ? rmem[ea] : '0; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rd_p(int a, string t);
    op(0, 1, 1, 0, 1, 0, 1, 1, '1, a, '0, t);
  endtask
  task automatic st_c(int a, logic g, logic w, logic [BW-1:0] b, logic [DW-1:0] d, string t);
    op(1, 0, 1, 0, 1, 0, g, w, b, a, d, t);
  endtask
  task automatic nx(logic v, logic g, logic w, logic [BW-1:0] b, logic [DW-1:0] d, string t);
    op(1, 1, v, 0, 1, 0, g, w, b, 0, d, t);
  endtask
  task automatic desel(string t);
    op(1, 0, 1, 1, 1, 0, 1, 1, '1, 0, '0, t);
  endtask

  // monitor: compare the bus on the cycle each item falls due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == edges) begin
      exp_t t;
      t = q.pop_front();
      n_cmp++;
      if (dq_oe !== t.drv || (t.drv && dq_out !== t.data)) begin
        n_bad++;
        $display("FAIL %s: actual oe=%0b data=%h expected oe=%0b data=%h",
                 t.tag, dq_oe, dq_out, t.drv, t.data);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; dq_in = '0; cpu_n = 1'b1; ctl_n = 1'b1; adv_n = 1'b1;
    sel_n = 1'b1; bank_hi = 1'b1; bank_lo_n = 1'b0; all_n = 1'b1; we_n = 1'b1;
    bwr_n = '1; oe_n = 1'b0; xor_ord = 1'b0; r_act = 1'b0;
    r_hi = '0; r_base = '0; r_cnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dq_oe === 1'b0, "R13 reset", DW'(dq_oe), '0);
    rst_n = 1'b1;

    // fill every word with global-write bursts (R8 start on controller strobe, R9 global)
    for (int blk = 0; blk < DEPTH / 4; blk++) begin
      st_c(blk * 4, 1'b0, 1'b1, '1, pat(blk * 4), "R8");
      for (int k = 1; k < 4; k++) nx(1'b0, 1'b0, 1'b1, '1, pat(blk * 4 + k), "R9");
    end

    // R1/R4/R10: linear burst wrapping from base 2
    rd_p(18, "R1");
    for (int k = 0; k < 3; k++) nx(1'b0, 1'b1, 1'b1, '1, '0, "R4");
    rd_p(3, "R10");
    nx(1'b0, 1'b1, 1'b1, '1, '0, "R4");

    // R5: interleaved order
    mode_il = 1'b1;
    rd_p(39, "R5");
    for (int k = 0; k < 3; k++) nx(1'b0, 1'b1, 1'b1, '1, '0, "R5");
    rd_p(41, "R5");
    for (int k = 0; k < 3; k++) nx(1'b0, 1'b1, 1'b1, '1, '0, "R5");
    mode_il = 1'b0;

    // R6: suspend holds the address
    rd_p(9, "R6");
    nx(1'b1, 1'b1, 1'b1, '1, '0, "R6");
    nx(1'b1, 1'b1, 1'b1, '1, '0, "R6");
    nx(1'b0, 1'b1, 1'b1, '1, '0, "R6");

    // R2: processor strobe with primary select high acts as continue, then suspend
    rd_p(20, "R1");
    op(0, 1, 0, 1, 1, 0, 1, 1, '1, 0, '0, "R2");
    op(0, 1, 1, 1, 1, 0, 1, 1, '1, 0, '0, "R2");

    // R3: deselect variants
    desel("R3");
    op(1, 0, 1, 0, 0, 0, 1, 1, '1, 5, '0, "R3");
    op(0, 1, 1, 0, 1, 1, 1, 1, '1, 5, '0, "R3");

    // R12: deselected continue/suspend with writes do nothing
    nx(1'b0, 1'b0, 1'b1, '1, 32'hDEAD_BEEF, "R12");
    nx(1'b1, 1'b0, 1'b1, '1, 32'hDEAD_BEEF, "R12");
    rd_p(20, "R12");
    for (int k = 0; k < 3; k++) nx(1'b0, 1'b1, 1'b1, '1, '0, "R12");

    // R7: processor start ignores write inputs
    op(0, 1, 1, 0, 1, 0, 0, 1, '1, 44, 32'h1234_5678, "R7");
    rd_p(44, "R7");

    // R9: byte lanes, all-high lanes read, global overrides lanes
    st_c(50, 1'b1, 1'b0, 4'b1010, 32'hAABB_CCDD, "R9");
    st_c(51, 1'b1, 1'b0, 4'b1111, 32'h0, "R9");
    st_c(52, 1'b0, 1'b0, 4'b1111, 32'h1122_3344, "R9");
    rd_p(50, "R9");
    nx(1'b0, 1'b1, 1'b1, '1, '0, "R9");
    nx(1'b0, 1'b1, 1'b1, '1, '0, "R9");

    // R8/R11: write on continue and suspend after a read start; read slot is silenced
    rd_p(56, "R11");
    nx(1'b0, 1'b1, 1'b0, 4'b0000, 32'hCAFE_F00D, "R8");
    nx(1'b1, 1'b0, 1'b1, '1, 32'h0BAD_CAFE, "R6");
    rd_p(56, "R8");
    nx(1'b0, 1'b1, 1'b1, '1, '0, "R8");

    // R11: read immediately followed by a controller write
    rd_p(30, "R11");
    st_c(31, 1'b0, 1'b1, '1, 32'h7777_0001, "R11");
    rd_p(31, "R11");

    // R11: asynchronous output enable
    rd_p(60, "R11");
    desel("R11");
    @(negedge clk);
    #2 oe_n = 1'b1;
    #1 chk(dq_oe === 1'b0, "R11 oe high", DW'(dq_oe), '0);
    oe_n = 1'b0;
    #1 chk(dq_oe === 1'b1 && dq_out === rmem[60], "R11 oe low", dq_out, rmem[60]);

    desel("R3");
    desel("R3");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10 drain", DW'(q.size()), '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule